// File: doc/BRIEF.md
# Branch and Next-PC Resolver

This combinational unit sits beside the program counter register of a single-cycle 32-bit integer core. It works out the address of the next instruction. Its inputs are the current PC, the two register operands, the immediate that the decoder has already extracted and sign-extended, the three-bit condition code from the instruction, and a two-bit control-flow class from the decoder. It drives the next PC and the return-link value that jumps write back to the destination register.

Four control-flow classes are handled. A sequential instruction steps to PC + 4. A conditional branch compares the two operands, using equality, signed order or unsigned order as the condition code selects, and goes to PC + immediate when the condition holds. A direct jump goes to PC + immediate. A register-indirect jump goes to operand 1 + immediate with bit 0 cleared. All arithmetic wraps modulo 2^32. The PC register is outside this block. After reset that register holds 0, so the first address this unit sees is 0.

Top module: `bnpc_unit`

## Requirements
- R1: With class branch (`flow_i` = 2'b01), condition 3'b000 is taken exactly when `rs1_i` equals `rs2_i`, and condition 3'b001 is taken exactly when they differ.
- R2: With class branch, condition 3'b100 is taken when `rs1_i` < `rs2_i` as two's-complement numbers, and condition 3'b101 is taken when `rs1_i` >= `rs2_i` as two's-complement numbers.
- R3: With class branch, condition 3'b110 is taken when `rs1_i` < `rs2_i` as unsigned numbers, and condition 3'b111 is taken when `rs1_i` >= `rs2_i` as unsigned numbers.
- R4: A taken branch drives `next_pc_o` = `pc_i` + `imm_i`. A branch that is not taken drives `next_pc_o` = `pc_i` + 4.
- R5: With class branch, conditions 3'b010 and 3'b011 are never taken, whatever the operands are.
- R6: With class direct jump (`flow_i` = 2'b10), `next_pc_o` = `pc_i` + `imm_i`.
- R7: With class register jump (`flow_i` = 2'b11), `next_pc_o` = (`rs1_i` + `imm_i`) with bit 0 forced to 0.
- R8: With class sequential (`flow_i` = 2'b00), `next_pc_o` = `pc_i` + 4. The operands, the immediate and the condition code have no effect in this class.
- R9: `link_o` always equals `pc_i` + 4, whatever the class.
- R10: Every address sum wraps modulo 2^32.
- R11: With the all-zero input pattern that the core presents after reset (PC 0, sequential), both `next_pc_o` and `link_o` are 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| rs1_i | input | XLEN | First register operand; base for register jumps |
| rs2_i | input | XLEN | Second register operand for comparisons |
| imm_i | input | XLEN | Sign-extended immediate from the decoder |
| funct3_i | input | 3 | Branch condition code |
| flow_i | input | 2 | Control-flow class: 00 sequential, 01 branch, 10 direct jump, 11 register jump |
| next_pc_o | output | XLEN | Address of the next instruction |
| link_o | output | XLEN | Return address, current PC plus one instruction |

## Verification
The bench builds the unit with its default values: a 32-bit datapath and a 4-byte instruction step. At that width the sign boundary between 0x7FFFFFFF and 0x80000000 and the all-ones pattern are reachable, so the bench can show signed and unsigned comparisons giving opposite results on the same operand pair. The same width lets the bench push PC-relative, sequential and register-jump sums across the top of the address space to show the wrap. A register-jump sum that comes out odd shows that bit 0 is cleared.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'b00,
    FLOW_BRANCH = 2'b01,
    FLOW_JAL    = 2'b10,
    FLOW_JALR   = 2'b11
  } flow_e;

  localparam logic [2:0] COND_EQ  = 3'b000;
  localparam logic [2:0] COND_NE  = 3'b001;
  localparam logic [2:0] COND_RS2 = 3'b010;
  localparam logic [2:0] COND_RS3 = 3'b011;
  localparam logic [2:0] COND_LT  = 3'b100;
  localparam logic [2:0] COND_GE  = 3'b101;
  localparam logic [2:0] COND_LTU = 3'b110;
  localparam logic [2:0] COND_GEU = 3'b111;

endpackage

// File: rtl/bnpc_cmp.sv
module bnpc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      cond_i,
  output logic            hit_o
);
  import bnpc_pkg::*;

  localparam int MSB = XLEN - 1;

  logic eq_w;
  logic lt_u_w;
  logic lt_s_w;

  // Unsigned less-than via the borrow of a widened subtraction.
  function automatic logic f_borrow(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [XLEN:0] diff;
    diff = {1'b0, x} - {1'b0, y};
    return diff[XLEN];
  endfunction

  // Signed less-than: signs differ -> x negative wins; else unsigned order.
  function automatic logic f_less_signed(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    if (x[MSB] != y[MSB]) return x[MSB];
    return f_borrow(x, y);
  endfunction

  assign eq_w   = (a_i == b_i);
  assign lt_u_w = f_borrow(a_i, b_i);
  assign lt_s_w = f_less_signed(a_i, b_i);

  always_comb begin
    unique case (cond_i)
      COND_EQ:  hit_o = eq_w;
      COND_NE:  hit_o = ~eq_w;
      COND_LT:  hit_o = lt_s_w;
      COND_GE:  hit_o = ~lt_s_w;
      COND_LTU: hit_o = lt_u_w;
      COND_GEU: hit_o = ~lt_u_w;
      COND_RS2,
      COND_RS3: hit_o = 1'b0;
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_addr.sv
module bnpc_addr #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] rel_o,
  output logic [XLEN-1:0] ind_o
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  // Modulo-2^XLEN sum; carry out is dropped.
  function automatic logic [XLEN-1:0] f_wrap_add(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  // Register-jump target: sum with bit 0 cleared.
  function automatic logic [XLEN-1:0] f_even(input logic [XLEN-1:0] x);
    return {x[XLEN-1:1], 1'b0};
  endfunction

  logic [XLEN-1:0] ind_raw_w;

  assign seq_o     = f_wrap_add(pc_i, STEP_V);
  assign rel_o     = f_wrap_add(pc_i, imm_i);
  assign ind_raw_w = f_wrap_add(base_i, imm_i);
  assign ind_o     = f_even(ind_raw_w);

endmodule

// File: rtl/bnpc_sel.sv
module bnpc_sel #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      flow_i,
  input  logic            hit_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] rel_i,
  input  logic [XLEN-1:0] ind_i,
  output logic            use_rel_o,
  output logic [XLEN-1:0] next_o
);
  import bnpc_pkg::*;

  flow_e flow_w;
  assign flow_w = flow_e'(flow_i);

  assign use_rel_o = (flow_w == FLOW_JAL) || ((flow_w == FLOW_BRANCH) && hit_i);

  always_comb begin
    if (flow_w == FLOW_JALR) next_o = ind_i;
    else if (use_rel_o)      next_o = rel_i;
    else                     next_o = seq_i;
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [2:0]      funct3_i,
  input  logic [1:0]      flow_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o
);

  // Named internal events, brought out for the checker.
  logic            cond_hit;
  logic            take_rel;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] rel_addr;
  logic [XLEN-1:0] ind_addr;

  bnpc_cmp #(.XLEN(XLEN)) cmp_i (
    .a_i    (rs1_i),
    .b_i    (rs2_i),
    .cond_i (funct3_i),
    .hit_o  (cond_hit)
  );

  bnpc_addr #(.XLEN(XLEN), .STEP(STEP)) addr_i (
    .pc_i   (pc_i),
    .base_i (rs1_i),
    .imm_i  (imm_i),
    .seq_o  (seq_addr),
    .rel_o  (rel_addr),
    .ind_o  (ind_addr)
  );

  bnpc_sel #(.XLEN(XLEN)) sel_i (
    .flow_i    (flow_i),
    .hit_i     (cond_hit),
    .seq_i     (seq_addr),
    .rel_i     (rel_addr),
    .ind_i     (ind_addr),
    .use_rel_o (take_rel),
    .next_o    (next_pc_o)
  );

  assign link_o = seq_addr;

endmodule

// File: rtl/bnpc_unit_chk.sv
module bnpc_unit_chk #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [XLEN-1:0] imm_i,
  input logic [2:0]      funct3_i,
  input logic [1:0]      flow_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] link_o,
  input logic            cond_hit,
  input logic            take_rel
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  always_comb begin
    if (flow_i == 2'b01 && funct3_i == 3'b000 && rs1_i == rs2_i)
      AST_EQ_SAME_TAKEN: assert (cond_hit) else $error("equal operands not taken"); // R1
    if (flow_i == 2'b01 && funct3_i == 3'b101 && rs1_i == rs2_i)
      AST_GE_SAME_TAKEN: assert (cond_hit) else $error("signed ge on equal not taken"); // R2
    if (flow_i == 2'b01 && funct3_i == 3'b111 && rs1_i == rs2_i)
      AST_GEU_SAME_TAKEN: assert (cond_hit) else $error("unsigned ge on equal not taken"); // R3
    if (flow_i == 2'b01 && !take_rel)
      AST_BR_FALLTHRU: assert (next_pc_o == link_o) else $error("untaken branch left sequence"); // R4
    if (flow_i == 2'b01 && (funct3_i == 3'b010 || funct3_i == 3'b011))
      AST_RSVD_NOT_TAKEN: assert (!take_rel) else $error("reserved condition taken"); // R5
    if (flow_i == 2'b10 && imm_i == STEP_V)
      AST_JAL_ONE_STEP: assert (next_pc_o == link_o) else $error("jal by one step mismatch"); // R6
    if (flow_i == 2'b11)
      AST_JALR_EVEN: assert (next_pc_o[0] == 1'b0) else $error("register jump target odd"); // R7
    if (flow_i == 2'b00)
      AST_SEQ_FALLTHRU: assert (next_pc_o == link_o && !take_rel) else $error("sequential left sequence"); // R8
  end

endmodule

bind bnpc_unit bnpc_unit_chk #(.XLEN(XLEN), .STEP(STEP)) chk_i (
  .pc_i      (pc_i),
  .rs1_i     (rs1_i),
  .rs2_i     (rs2_i),
  .imm_i     (imm_i),
  .funct3_i  (funct3_i),
  .flow_i    (flow_i),
  .next_pc_o (next_pc_o),
  .link_o    (link_o),
  .cond_hit  (cond_hit),
  .take_rel  (take_rel)
);

// File: tb/bnpc_unit_tb_top.sv
module bnpc_unit_tb_top;

  localparam int XLEN = 32;
  localparam int NVEC = 21;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] rs1;
    logic [31:0] rs2;
    logic [31:0] imm;
    logic [2:0]  f3;
    logic [1:0]  flow;
    logic [31:0] exp_next;
    logic [7:0]  req;
  } vec_t;

  // flow: 0 sequential, 1 branch, 2 direct jump, 3 register jump
  localparam vec_t VECS [NVEC] = '{
    '{32'h100, 32'h5, 32'h5, 32'h20, 3'd0, 2'd1, 32'h120, 8'd1},                     // R1 eq taken
    '{32'h100, 32'h5, 32'h6, 32'h20, 3'd0, 2'd1, 32'h104, 8'd1},                     // R1 eq not taken (R4)
    '{32'h100, 32'h1, 32'h2, 32'hFFFFFFF8, 3'd1, 2'd1, 32'h0F8, 8'd1},               // R1 ne taken, backward
    '{32'h100, 32'h9, 32'h9, 32'h20, 3'd1, 2'd1, 32'h104, 8'd1},                     // R1 ne not taken
    '{32'h100, 32'hFFFFFFFF, 32'h1, 32'h20, 3'd4, 2'd1, 32'h120, 8'd2},              // R2 -1 < 1 signed
    '{32'h100, 32'hFFFFFFFF, 32'h1, 32'h20, 3'd5, 2'd1, 32'h104, 8'd2},              // R2 -1 >= 1 false
    '{32'h100, 32'h7FFFFFFF, 32'h80000000, 32'h20, 3'd5, 2'd1, 32'h120, 8'd2},       // R2 max >= min
    '{32'h100, 32'h7FFFFFFF, 32'h80000000, 32'h20, 3'd4, 2'd1, 32'h104, 8'd2},       // R2 max < min false
    '{32'h100, 32'hFFFFFFFF, 32'h1, 32'h20, 3'd6, 2'd1, 32'h104, 8'd3},              // R3 all-ones not < 1
    '{32'h100, 32'h1, 32'hFFFFFFFF, 32'h20, 3'd6, 2'd1, 32'h120, 8'd3},              // R3 1 < all-ones
    '{32'h100, 32'h80000000, 32'h7FFFFFFF, 32'h20, 3'd7, 2'd1, 32'h120, 8'd3},       // R3 geu taken
    '{32'h100, 32'h3, 32'h3, 32'h20, 3'd7, 2'd1, 32'h120, 8'd3},                     // R3 geu equal
    '{32'h100, 32'h3, 32'h3, 32'h20, 3'd2, 2'd1, 32'h104, 8'd5},                     // R5 code 010
    '{32'h100, 32'h0, 32'h1, 32'h20, 3'd3, 2'd1, 32'h104, 8'd5},                     // R5 code 011
    '{32'h200, 32'h0, 32'h0, 32'hFFFFFF00, 3'd0, 2'd2, 32'h100, 8'd6},               // R6 backward jump
    '{32'h200, 32'hDEAD, 32'hBEEF, 32'h400, 3'd5, 2'd2, 32'h600, 8'd6},              // R6 forward jump
    '{32'h200, 32'h1001, 32'h0, 32'h10, 3'd0, 2'd3, 32'h1010, 8'd7},                 // R7 odd sum cleared
    '{32'h200, 32'h2000, 32'h0, 32'h2, 3'd0, 2'd3, 32'h2002, 8'd7},                  // R7 even sum kept
    '{32'h300, 32'h12345678, 32'h9ABCDEF0, 32'h7FF, 3'd0, 2'd0, 32'h304, 8'd8},     // R8 sequential
    '{32'hFFFFFFF0, 32'h0, 32'h0, 32'h20, 3'd0, 2'd2, 32'h10, 8'd10},                // R10 relative wrap
    '{32'hFFFFFFFC, 32'hFFFFFFFF, 32'h0, 32'h2, 3'd0, 2'd0, 32'h0, 8'd10}            // R10 sequential wrap
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [XLEN-1:0] pc, rs1, rs2, imm;
  logic [2:0]      f3;
  logic [1:0]      flow;
  logic [XLEN-1:0] next_pc, link;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bnpc_unit #(.XLEN(XLEN), .STEP(4)) dut_i (
    .pc_i      (pc),
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .imm_i     (imm),
    .funct3_i  (f3),
    .flow_i    (flow),
    .next_pc_o (next_pc),
    .link_o    (link)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] i, input logic [2:0] c, input logic [1:0] fl);
    @(posedge clk);
    #1;
    pc = p; rs1 = a; rs2 = b; imm = i; f3 = c; flow = fl;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      finish_run();
    end
  end

  initial begin
    pc = '0; rs1 = '0; rs2 = '0; imm = '0; f3 = '0; flow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset-time pattern, PC 0 sequential
    check("R11 next", next_pc, 32'h4);
    check("R11 link", link, 32'h4);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].pc, VECS[k].rs1, VECS[k].rs2, VECS[k].imm, VECS[k].f3, VECS[k].flow);
      check($sformatf("R%0d vec%0d next", VECS[k].req, k), next_pc, VECS[k].exp_next);
      check($sformatf("R9 vec%0d link", k), link, VECS[k].pc + 32'd4);
    end

    // R8: operands, immediate and condition code ignored in sequential class
    for (int k = 0; k < 8; k++) begin
      apply(32'h500, 32'h11111111 * k, ~(32'h01010101 * k), 32'hFFFFF000 + k, 3'(k), 2'd0);
      check($sformatf("R8 ignore k%0d", k), next_pc, 32'h504);
    end

    // R4: taken branch by a large negative offset, with wrap (R10)
    apply(32'h10, 32'h0, 32'h0, 32'hFFFFFFE0, 3'd0, 2'd1);
    check("R4 R10 taken negative wrap", next_pc, 32'hFFFFFFF0);

    // R7 with R10: register jump sum wrapping and odd
    apply(32'h40, 32'hFFFFFFFF, 32'h0, 32'h2, 3'd1, 2'd3);
    check("R7 R10 register wrap", next_pc, 32'h0);
    check("R9 link on register jump", link, 32'h44);

    // R5 across many operand pairs for both reserved codes
    for (int k = 0; k < 4; k++) begin
      apply(32'h800, 32'h1 << k, 32'h1 << (3 - k), 32'h100, (k % 2 == 0) ? 3'd2 : 3'd3, 2'd1);
      check($sformatf("R5 reserved k%0d", k), next_pc, 32'h804);
    end

    finish_run();
  end

endmodule